// File: doc/BRIEF.md
# Multi-Read Register File from Replicated Dual-Port RAMs

This block is a register file with a single write port and a configurable number of independent read ports, each with a synchronous read. It is assembled from identical copies of a two-port synchronous RAM. Every copy takes the same write traffic on its first port, so all copies always hold the same contents. The second port of each copy is a private read port. When no write is in progress, the first port of a copy is free and serves one more read port. With `NUM_RD` read ports the block uses `ceil(NUM_RD/2)` copies.

Inside a two-port RAM, reading one port at the address the other port is writing in the same cycle does not give the new value. The block compares each private read address with the write address and registers the result. In the following cycle it substitutes the registered write data, so a read issued in the same cycle as a write to that address returns the new value. The block therefore behaves as read-after-write. The old contents of a location cannot be read in the cycle that overwrites it.

Top module: `rf_multiread`

## Requirements
- R1: The block has `NUM_RD` read ports and uses `ceil(NUM_RD/2)` RAM copies. Read ports 0 to C-1, where C is the copy count, are private, and private port k reads the second port of copy k. The remaining ports are shared, and shared port C+s uses the first port of copy s. All ports read independent addresses in the same cycle. Address field k of `rd_addr_i` is bits [k*ADDR_W +: ADDR_W], and data field k of `rd_data_o` is bits [k*DATA_W +: DATA_W].
- R2: Reads are synchronous. A read address sampled at a rising clock edge gives its data on the matching output field after that edge. The data holds until the next edge.
- R3: When `wr_en_i` is high at a rising edge, `wr_data_i` is stored at `wr_addr_i` in every copy. Any port that reads that address in a later cycle returns the new value.
- R4: If a private read port presents the write address in a write cycle, its output after that edge is the new write data, not the old contents.
- R5: In a write cycle, a private read port that presents a different address returns the stored contents of its own address.
- R6: A shared read port returns the stored contents of its address only in cycles without a write. In a write cycle its output after the edge equals the write data, whatever address it presents.
- R7: While `rst_n` is low, every read output field is zero.
- R8: For two consecutive writes to the same address, a private read of that address issued with the second write returns the second value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the output registers |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | DATA_W | Write data |
| rd_addr_i | input | NUM_RD*ADDR_W | Packed read addresses, one field per port |
| rd_data_o | output | NUM_RD*DATA_W | Packed read data, one field per port |

## Verification
The bench builds the block with three read ports, 16-bit data and a 4-bit address. This gives two RAM copies with two private ports and one shared port. Private forwarding, reads of unrelated addresses during a write, and the shared port losing its read slot to a write can therefore all be observed in one run. Every read output is compared each cycle against a reference array that is updated by the bench's own write model.

// File: rtl/rf_pkg.sv
package rf_pkg;
  // Number of two-port RAM copies needed for a given read-port count.
  function automatic int unsigned copies(input int unsigned n_rd);
    return (n_rd + 1) / 2;
  endfunction
endpackage

// File: rtl/rf_dp_ram.sv
// Two-port synchronous RAM copy: port A writes (write-first readback),
// port B reads (returns the old word when A writes the same address).
module rf_dp_ram #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_en,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic              b_en,
  input  logic [ADDR_W-1:0] b_addr,
  output logic [DATA_W-1:0] b_rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] a_q, a_d, b_q, b_d;

  // storage array, no reset
  always_ff @(posedge clk) begin
    if (a_en && a_we) mem[a_addr] <= a_wdata;
  end

  always_comb begin
    a_d = a_q;
    if (a_en) a_d = a_we ? a_wdata : mem[a_addr];
    b_d = b_q;
    if (b_en) b_d = mem[b_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      a_q <= a_d;
      b_q <= b_d;
    end
  end

  assign a_rdata = a_q;
  assign b_rdata = b_q;
endmodule

// File: rtl/rf_fwd.sv
// Per-port forwarding: remembers whether the read hit the write address
// and steers the registered write data over the RAM output.
module rf_fwd #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] ram_q,
  input  logic [DATA_W-1:0] fwd_q,
  output logic [DATA_W-1:0] rd_data
);
  logic hit_q, hit_d;

  always_comb hit_d = wr_en && (wr_addr == rd_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_q <= 1'b0;
    else        hit_q <= hit_d;
  end

  assign rd_data = hit_q ? fwd_q : ram_q;
endmodule

// File: rtl/rf_multiread.sv
module rf_multiread #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4,
  parameter int NUM_RD = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en_i,
  input  logic [ADDR_W-1:0]        wr_addr_i,
  input  logic [DATA_W-1:0]        wr_data_i,
  input  logic [NUM_RD*ADDR_W-1:0] rd_addr_i,
  output logic [NUM_RD*DATA_W-1:0] rd_data_o
);
  localparam int COPIES = int'(rf_pkg::copies(NUM_RD));
  localparam int SHARED = NUM_RD - COPIES;

  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic [ADDR_W-1:0] rd_addr [NUM_RD];
  logic [DATA_W-1:0] a_q [COPIES];
  logic [DATA_W-1:0] b_q [COPIES];

  // forwarded write data, clock-enabled by the write strobe
  always_comb wdata_d = wr_en_i ? wr_data_i : wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wdata_q <= '0;
    else        wdata_q <= wdata_d;
  end

  for (genvar r = 0; r < NUM_RD; r++) begin : g_unpack
    assign rd_addr[r] = rd_addr_i[r*ADDR_W +: ADDR_W];
  end

  for (genvar c = 0; c < COPIES; c++) begin : g_copy
    logic [ADDR_W-1:0] a_addr;
    logic              a_en;

    if (c < SHARED) begin : g_shared_a
      assign a_addr = wr_en_i ? wr_addr_i : rd_addr[COPIES+c];
      assign a_en   = 1'b1;
    end else begin : g_write_a
      assign a_addr = wr_addr_i;
      assign a_en   = wr_en_i;
    end

    rf_dp_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_ram (
      .clk     (clk),
      .rst_n   (rst_n),
      .a_en    (a_en),
      .a_we    (wr_en_i),
      .a_addr  (a_addr),
      .a_wdata (wr_data_i),
      .a_rdata (a_q[c]),
      .b_en    (1'b1),
      .b_addr  (rd_addr[c]),
      .b_rdata (b_q[c])
    );

    rf_fwd #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_fwd (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en_i),
      .wr_addr (wr_addr_i),
      .rd_addr (rd_addr[c]),
      .ram_q   (b_q[c]),
      .fwd_q   (wdata_q),
      .rd_data (rd_data_o[c*DATA_W +: DATA_W])
    );
  end

  for (genvar s = 0; s < SHARED; s++) begin : g_shared_out
    assign rd_data_o[(COPIES+s)*DATA_W +: DATA_W] = a_q[s];
  end
endmodule

// File: rtl/rf_multiread_chk.sv
module rf_multiread_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4,
  parameter int NUM_RD = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     wr_en_i,
  input logic [ADDR_W-1:0]        wr_addr_i,
  input logic [DATA_W-1:0]        wr_data_i,
  input logic [NUM_RD*ADDR_W-1:0] rd_addr_i,
  input logic [NUM_RD*DATA_W-1:0] rd_data_o
);
  localparam int COPIES = int'(rf_pkg::copies(NUM_RD));
  localparam int SHARED = NUM_RD - COPIES;

  logic [1:0] armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          armed <= '0;
    else if (armed != 2) armed <= armed + 2'd1;
  end

  assert_reset_zero_R7: assert property (@(posedge clk)
    !rst_n |=> rd_data_o == '0);

  for (genvar r = 0; r < COPIES; r++) begin : g_priv
    assert_forward_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && wr_addr_i == rd_addr_i[r*ADDR_W +: ADDR_W])
      |=> rd_data_o[r*DATA_W +: DATA_W] == $past(wr_data_i));
  end

  for (genvar s = 0; s < SHARED; s++) begin : g_shr
    assert_shared_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_i |=> rd_data_o[(COPIES+s)*DATA_W +: DATA_W] == $past(wr_data_i));
  end

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed == 2 && !$past(wr_en_i) && !$past(wr_en_i, 2)
      && $past(rd_addr_i) == $past(rd_addr_i, 2))
    |-> $stable(rd_data_o));
endmodule

bind rf_multiread rf_multiread_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_RD(NUM_RD)
) i_chk (
  .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o)
);

// File: tb/test_rf_multiread.sv
module test_rf_multiread;
  localparam int DW = 16;
  localparam int AW = 4;
  localparam int NR = 3;
  localparam int NC = 2;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [NR*AW-1:0] rd_addr = '0;
  logic [NR*DW-1:0] rd_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [DW-1:0] ref_mem [DEPTH];

  always #10 clk = ~clk;

  rf_multiread #(.DATA_W(DW), .ADDR_W(AW), .NUM_RD(NR)) i_rf_multiread (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  task automatic check(input string tag, input int port,
                       input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s port %0d: got %h expected %h", tag, port, got, exp);
    end
  endtask

  // One cycle, entered and left at a falling edge.
  task automatic cycle(input bit we, input int wa, input logic [DW-1:0] wd,
                       input int a0, input int a1, input int a2,
                       input string tag);
    logic [DW-1:0] exp [NR];
    int ra [NR];
    ra[0] = a0; ra[1] = a1; ra[2] = a2;
    wr_en = we; wr_addr = AW'(wa); wr_data = wd;
    for (int r = 0; r < NR; r++) rd_addr[r*AW +: AW] = AW'(ra[r]);
    for (int r = 0; r < NR; r++) begin
      if (r < NC) exp[r] = (we && wa == ra[r]) ? wd : ref_mem[ra[r]];
      else        exp[r] = we ? wd : ref_mem[ra[r]];
    end
    if (we) ref_mem[wa] = wd;
    @(posedge clk);
    @(negedge clk);
    for (int r = 0; r < NR; r++) check(tag, r, rd_data[r*DW +: DW], exp[r]);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    wr_en = 1'b1; wr_data = 16'hDEAD; rd_addr = '1;
    repeat (3) @(negedge clk);
    for (int r = 0; r < NR; r++) check("R7", r, rd_data[r*DW +: DW], '0);
    wr_en = 1'b0;
    rst_n = 1'b1;
  endtask

  task automatic t_fill();
    // every port reads the address being written: private forward, shared gets write data
    for (int a = 0; a < DEPTH; a++)
      cycle(1, a, DW'(16'h1000 + a * 16'h0111), a, a, a, "R3");
    for (int a = 0; a < DEPTH; a++)
      cycle(0, 0, '0, a, a, a, "R3");
  endtask

  task automatic t_ports();
    for (int a = 0; a < DEPTH; a++)
      cycle(0, 0, '0, a, (a + 5) % DEPTH, (a + 11) % DEPTH, "R1");
  endtask

  task automatic t_hold();
    for (int i = 0; i < 3; i++) cycle(0, 0, '0, 2, 13, 8, "R2");
  endtask

  task automatic t_forward();
    cycle(1, 3, 16'hA5A5, 3, 3, 7, "R4");
    cycle(0, 0, '0, 3, 3, 3, "R4");
  endtask

  task automatic t_other();
    cycle(1, 5, 16'h5EED, 6, 9, 4, "R5");
    cycle(0, 0, '0, 5, 6, 9, "R5");
  endtask

  task automatic t_shared();
    cycle(1, 12, 16'hC0DE, 0, 1, 14, "R6");
    cycle(0, 0, '0, 0, 1, 14, "R6");
    cycle(0, 0, '0, 0, 1, 12, "R6");
  endtask

  task automatic t_b2b();
    cycle(1, 10, 16'h1111, 10, 2, 10, "R8");
    cycle(1, 10, 16'h2222, 10, 10, 10, "R8");
    cycle(0, 0, '0, 10, 10, 10, "R8");
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_fill();
    t_ports();
    t_hold();
    t_forward();
    t_other();
    t_shared();
    t_b2b();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule